// File: doc/BRIEF.md
# Fault-Aware Instruction Detour Stage

This stage sits in a simple in-order pipeline between instruction fetch and decode. Every instruction handed over by fetch is looked up by its opcode in a small table. Each table entry holds one usable bit and an 8-bit start address of a replacement routine. When the usable bit is set, the instruction moves to decode unchanged, one cycle later. When it is clear, the stage takes the instruction, holds main fetch, and streams a replacement routine out of a microcode ROM to decode. It does this under the control of its own routine counter.

Routines may jump inside the ROM through a reserved jump opcode that only moves the routine counter. A reserved all-ones word closes a routine. Neither of these words ever reaches decode. After the closing word, fetch is released and the next program instruction follows in order. An external fault detector rewrites table entries through a write port. An opcode that is marked unusable but has a null start address cannot be recovered. It raises a sticky fault output and freezes the stage until reset.

Top module: `insn_detour_stage`

## Requirements
- R1: After reset, dec_valid, fetch_hold and unrecoverable are low, and every opcode is marked usable with a null (zero) routine address.
- R2: An instruction accepted from fetch (fetch_valid high and fetch_hold low at a clock edge) whose opcode (bits 31:26) is usable appears on dec_insn with dec_valid high after that same edge, bit-for-bit unchanged.
- R3: An accepted instruction whose opcode is unusable and has a non-zero routine address is not forwarded. From the next cycle, ROM words are read starting at that address, and each ordinary word is forwarded to decode in address order, one per cycle.
- R4: A ROM word whose bits 31:26 equal 6'h3E is an in-routine jump. It loads bits 7:0 into the routine counter, is not forwarded, and does not advance main fetch.
- R5: The ROM word 32'hFFFF_FFFF ends the routine. It is not forwarded, fetch_hold drops after that edge, and the next program instruction is accepted from the following cycle.
- R6: A pulse on tbl_we writes tbl_usable and tbl_start for opcode tbl_opcode. The new entry governs instructions accepted after that edge, and writing usable back restores plain pass-through.
- R7: An accepted unusable opcode with a zero routine address sets unrecoverable. It stays set, and fetch_hold stays high and dec_valid low until reset.
- R8: A cycle with fetch_valid low produces no decode output.
- R9: fetch_hold is high during every routine cycle. The decode stream always follows program order, so back-to-back unusable instructions each run their full routine in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch presents an instruction |
| fetch_insn | input | 32 | Instruction from fetch |
| fetch_hold | output | 1 | Hold main fetch on the current instruction |
| dec_valid | output | 1 | Decode output carries an instruction |
| dec_insn | output | 32 | Instruction to decode |
| tbl_we | input | 1 | Table write strobe from the fault detector |
| tbl_opcode | input | 6 | Opcode entry to write |
| tbl_usable | input | 1 | New usable bit |
| tbl_start | input | 8 | New routine start address |
| rom_addr | output | 8 | Routine counter, ROM read address |
| rom_data | input | 32 | ROM word at rom_addr, same cycle |
| unrecoverable | output | 1 | Sticky unrecoverable-fault flag |

## Verification
The assertions rely on a ROM that answers combinationally in the same cycle and on routines that always reach the closing word. They also assume fetch holds its instruction while fetch_hold is high. The bench follows all three. Its fetch model advances only on edges where it presented a valid word and saw no hold. Every routine it places in the ROM ends in the all-ones marker, and each jump targets an address that leads to one. Address 0 is kept free of routine code, so a zero start address can only mean the null case.

// File: rtl/insn_detour_stage.sv
module insn_detour_stage #(
  parameter int unsigned IW      = 32,
  parameter int unsigned OPW     = 6,
  parameter int unsigned AW      = 8,
  parameter logic [31:0] END_WORD = 32'hFFFF_FFFF,
  parameter int unsigned JUMP_OP = 62
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [IW-1:0] fetch_insn,
  output logic          fetch_hold,
  output logic          dec_valid,
  output logic [IW-1:0] dec_insn,
  input  logic          tbl_we,
  input  logic [OPW-1:0] tbl_opcode,
  input  logic          tbl_usable,
  input  logic [AW-1:0] tbl_start,
  output logic [AW-1:0] rom_addr,
  input  logic [IW-1:0] rom_data,
  output logic          unrecoverable
);
  localparam int unsigned NOP = 1 << OPW;
  localparam logic [OPW-1:0] JOP = OPW'(JUMP_OP);
  localparam logic [IW-1:0]  ENDW = IW'(END_WORD);

  logic [NOP-1:0] usable_q;
  logic [AW-1:0]  start_q [NOP];
  logic           busy;
  logic [AW-1:0]  rpc;

  wire [OPW-1:0] f_op   = fetch_insn[IW-1 -: OPW];
  wire [OPW-1:0] r_op   = rom_data[IW-1 -: OPW];
  wire           take   = fetch_valid & ~fetch_hold;
  wire           r_end  = rom_data == ENDW;
  wire           r_jump = (r_op == JOP) & ~r_end;

  assign fetch_hold = busy | unrecoverable;
  assign rom_addr   = rpc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NOP; i++) begin
        usable_q[i] <= 1'b1;
        start_q[i]  <= '0;
      end
    end else if (tbl_we) begin
      usable_q[tbl_opcode] <= tbl_usable;
      start_q[tbl_opcode]  <= tbl_start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      unrecoverable <= 1'b0;
      rpc           <= '0;
      dec_valid     <= 1'b0;
      dec_insn      <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (busy) begin
        if (r_end) begin
          busy <= 1'b0;
        end else if (r_jump) begin
          rpc <= rom_data[AW-1:0];
        end else begin
          dec_valid <= 1'b1;
          dec_insn  <= rom_data;
          rpc       <= rpc + 1'b1;
        end
      end else if (take) begin
        if (usable_q[f_op]) begin
          dec_valid <= 1'b1;
          dec_insn  <= fetch_insn;
        end else if (start_q[f_op] == '0) begin
          unrecoverable <= 1'b1;
        end else begin
          busy <= 1'b1;
          rpc  <= start_q[f_op];
        end
      end
    end
  end

  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && usable_q[f_op]) |=> (dec_valid && dec_insn == $past(fetch_insn))); // R2
  AST_ROUTINE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !r_end && !r_jump) |=> (dec_valid && rom_addr == $past(rom_addr) + 1'b1)); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && r_jump) |=> (busy && !dec_valid && rom_addr == $past(rom_data[AW-1:0]))); // R4
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && r_end) |=> (!fetch_hold && !dec_valid)); // R5
  AST_NO_MARKER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_insn != ENDW); // R5
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |=> (unrecoverable && fetch_hold && !dec_valid)); // R7
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !dec_valid); // R8
endmodule

// File: tb/insn_detour_stage_tb.sv
`timescale 1ns/1ps
module insn_detour_stage_tb;
  localparam logic [31:0] ENDW = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_insn = '0;
  logic fetch_hold, dec_valid, unrecoverable;
  logic [31:0] dec_insn;
  logic tbl_we = 1'b0;
  logic [5:0] tbl_opcode = '0;
  logic tbl_usable = 1'b1;
  logic [7:0] tbl_start = '0;
  logic [7:0] rom_addr;
  logic [31:0] rom_data;
  logic [31:0] rom [256];

  int checks = 0;
  int fails = 0;

  logic        m_ok  [64];
  logic [7:0]  m_ptr [64];
  logic [31:0] prog [16];
  logic [31:0] got [$];
  logic [31:0] exp_q [$];
  bit          saw_hold;

  always #2.5 clk = ~clk;
  assign rom_data = rom[rom_addr];

  insn_detour_stage u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_insn(fetch_insn), .fetch_hold(fetch_hold),
    .dec_valid(dec_valid), .dec_insn(dec_insn),
    .tbl_we(tbl_we), .tbl_opcode(tbl_opcode), .tbl_usable(tbl_usable), .tbl_start(tbl_start),
    .rom_addr(rom_addr), .rom_data(rom_data), .unrecoverable(unrecoverable)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
    return {op, rest};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_valid = 1'b0;
    tbl_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin
      m_ok[i] = 1'b1;
      m_ptr[i] = '0;
    end
  endtask

  task automatic tbl_write(input logic [5:0] op, input logic ok, input logic [7:0] ptr);
    tbl_we = 1'b1; tbl_opcode = op; tbl_usable = ok; tbl_start = ptr;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    m_ok[op] = ok; m_ptr[op] = ptr;
  endtask

  task automatic build_exp(input int n);
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      logic [5:0] op;
      op = prog[i][31:26];
      if (m_ok[op]) exp_q.push_back(prog[i]);
      else if (m_ptr[op] == 0) break;
      else begin
        logic [7:0] pc;
        pc = m_ptr[op];
        for (int g = 0; g < 64; g++) begin
          if (rom[pc] == ENDW) break;
          if (rom[pc][31:26] == 6'h3E) pc = rom[pc][7:0];
          else begin
            exp_q.push_back(rom[pc]);
            pc = pc + 8'd1;
          end
        end
      end
    end
  endtask

  task automatic run_prog(input int n, input bit gaps, input int limit);
    int fp = 0;
    int idle = 0;
    got.delete();
    saw_hold = 1'b0;
    for (int cyc = 0; cyc < limit; cyc++) begin
      bit adv;
      if (fp < n && !(gaps && (cyc % 3 == 2))) begin
        fetch_valid = 1'b1; fetch_insn = prog[fp];
      end else begin
        fetch_valid = 1'b0; fetch_insn = 32'h0BAD_0BAD;
      end
      adv = fetch_valid && !fetch_hold;
      @(posedge clk); #1;
      if (adv) fp++;
      if (dec_valid) got.push_back(dec_insn);
      if (fetch_hold) saw_hold = 1'b1;
      if (fp == n && !fetch_hold) idle++;
      if (idle > 3) break;
    end
    fetch_valid = 1'b0;
  endtask

  task automatic cmp_stream(input string tag);
    chk(got.size() == exp_q.size(), {tag, " length"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], tag, got[i], exp_q[i]);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!dec_valid, "R1 dec_valid", dec_valid, 0);
    chk(!fetch_hold, "R1 fetch_hold", fetch_hold, 0);
    chk(!unrecoverable, "R1 unrecoverable", unrecoverable, 0);
  endtask

  task automatic t_passthru();
    prog[0] = mk(6'h10, 26'h0000111); prog[1] = mk(6'h3E, 26'h0000022);
    prog[2] = mk(6'h3F, 26'h3FFFFFE); prog[3] = mk(6'h00, 26'h1234567);
    build_exp(4);
    run_prog(4, 1'b0, 40);
    cmp_stream("R1 R2 pass-through");
    run_prog(4, 1'b1, 40);
    cmp_stream("R8 gaps in fetch_valid");
  endtask

  task automatic t_routine();
    rom[8'h20] = 32'hA000_0001; rom[8'h21] = 32'hA000_0002; rom[8'h22] = ENDW;
    tbl_write(6'h10, 1'b0, 8'h20);
    prog[0] = mk(6'h01, 26'h0000AAA); prog[1] = mk(6'h10, 26'h0000BBB);
    prog[2] = mk(6'h02, 26'h0000CCC);
    build_exp(3);
    run_prog(3, 1'b0, 40);
    cmp_stream("R3 R5 routine replaces insn");
    chk(saw_hold, "R9 hold during routine", saw_hold, 1);
  endtask

  task automatic t_jump();
    rom[8'h40] = 32'hC000_0001; rom[8'h41] = mk(6'h3E, 26'h0000050);
    rom[8'h42] = 32'hDEAD_0000; rom[8'h50] = 32'hE000_0001; rom[8'h51] = ENDW;
    tbl_write(6'h11, 1'b0, 8'h40);
    prog[0] = mk(6'h11, 26'h1); prog[1] = mk(6'h03, 26'h2);
    build_exp(2);
    run_prog(2, 1'b0, 40);
    cmp_stream("R4 in-routine jump");
  endtask

  task automatic t_back_to_back();
    prog[0] = mk(6'h10, 26'h1); prog[1] = mk(6'h11, 26'h2);
    prog[2] = mk(6'h10, 26'h3); prog[3] = mk(6'h04, 26'h4);
    build_exp(4);
    run_prog(4, 1'b1, 80);
    cmp_stream("R9 back-to-back routines");
  endtask

  task automatic t_restore();
    tbl_write(6'h10, 1'b1, 8'h20);
    prog[0] = mk(6'h10, 26'h0000777); prog[1] = mk(6'h11, 26'h5);
    build_exp(2);
    run_prog(2, 1'b0, 40);
    cmp_stream("R6 usable restored");
  endtask

  task automatic t_fatal();
    tbl_write(6'h12, 1'b0, 8'h00);
    prog[0] = mk(6'h05, 26'h9); prog[1] = mk(6'h12, 26'hA); prog[2] = mk(6'h06, 26'hB);
    build_exp(3);
    run_prog(3, 1'b0, 15);
    cmp_stream("R7 output before fault");
    chk(unrecoverable, "R7 unrecoverable set", unrecoverable, 1);
    chk(fetch_hold, "R7 fetch held", fetch_hold, 1);
    do_reset();
    chk(!unrecoverable, "R1 reset clears fault", unrecoverable, 0);
    prog[0] = mk(6'h12, 26'hC);
    build_exp(1);
    run_prog(1, 1'b0, 20);
    cmp_stream("R1 table reset to usable");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = ENDW;
    t_reset();
    t_passthru();
    t_routine();
    t_jump();
    t_back_to_back();
    t_restore();
    t_fatal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule